// File: doc/BRIEF.md
# Period-Match Timer with Postscaler

This block is an 8-bit up-counter that advances on ticks from a selectable input prescaler. It compares the count against a programmable period value on every tick. When the two are equal, the next tick returns the counter to zero instead of incrementing it. That equality event is exported as a one-cycle time-base pulse for neighbouring logic, such as a PWM generator. The same event also clocks a postscaler. Every Nth match, with N between 1 and 16, the postscaler sets a sticky interrupt flag.

Software sees one write port with four targets, picked by a 2-bit select: the counter itself, the period value, a control byte, and an interrupt byte. The control byte holds the run bit, the prescaler code and the postscaler code. The interrupt byte holds the interrupt enable and a flag-clear bit. The flag drives the interrupt request only while the enable is set.

Top module: `match_timer`

## Requirements
- R1: After a synchronous reset, the counter is 0, the period is all ones, the control byte is 0 (stopped), the flag and enable are 0, and both the match pulse and the interrupt request are low.
- R2: While the run bit (control bit 0) is 1, the counter advances by one on each prescaled tick. While it is 0, the counter holds its value.
- R3: Control bits [2:1] set the prescaler: 00 ticks every clock, 01 every 4th clock, and 10 or 11 every 16th clock.
- R4: On a tick where the count equals the period, the counter goes to 0 on that edge and the match output is high for the following cycle. With period P and prescale D, matches repeat every (P+1)*D clocks, counted from a control write that starts the timer at count 0.
- R5: Control bits [6:3] hold a postscale code C. The flag is set on every (C+1)th match, on the same edge as that match, and is never set by anything else.
- R6: The flag is sticky. Writing select 3 with data bit 1 set clears it, unless a postscaler terminal event occurs on the same edge, in which case the set wins.
- R7: The interrupt output is high exactly when the flag is set and the enable (select 3, data bit 0) is set.
- R8: Writing select 0 loads the counter with the write data on that edge and clears the prescaler and postscaler counts. No tick occurs on that edge.
- R9: Writing select 2 loads the control byte and clears the prescaler and postscaler counts. No tick occurs on that edge.
- R10: Writing select 1 loads the period value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 counter, 1 period, 2 control, 3 interrupt |
| wr_data | input | 8 | Write data |
| count_o | output | 8 | Current counter value |
| match_o | output | 1 | One-cycle pulse after a period match |
| irq_flag_o | output | 1 | Sticky postscaled interrupt flag |
| irq_o | output | 1 | Interrupt request (flag and enable) |

## Verification
The bench builds the block with its default widths: an 8-bit counter and a 4-bit postscaler. Under these values the reset period of 255 gives a full 256-tick wrap. A zero period at the divide-by-16 prescale gives back-to-back matches. The postscale code 15 needs sixteen matches before the flag sets, so the largest divide ratio is observable within a few hundred cycles. The scoreboard predicts the clock cycle of every match pulse from the period and prescale. A counter write made mid-run checks that both the prescaler phase and the postscaler progress restart.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam logic [1:0] SEL_CNT = 2'd0;
  localparam logic [1:0] SEL_PER = 2'd1;
  localparam logic [1:0] SEL_CTL = 2'd2;
  localparam logic [1:0] SEL_IRQ = 2'd3;

  localparam int PRE_W = 4;

  localparam int CTL_ON      = 0;
  localparam int CTL_PRE_LO  = 1;
  localparam int CTL_POST_LO = 3;

  // terminal value of the prescaler count for each code
  function automatic logic [PRE_W-1:0] pre_limit(input logic [1:0] code);
    case (code)
      2'b00:   pre_limit = PRE_W'(0);
      2'b01:   pre_limit = PRE_W'(3);
      default: pre_limit = PRE_W'(15);
    endcase
  endfunction
endpackage

// File: rtl/mt_prescale.sv
module mt_prescale
  import mt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       clr,
  input  logic [1:0] code,
  output logic       tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] lim;

  assign lim  = pre_limit(code);
  assign tick = run && !clr && (pre_q == lim);

  always_ff @(posedge clk) begin
    if (rst || clr)  pre_q <= '0;
    else if (tick)   pre_q <= '0;
    else if (run)    pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/mt_count.sv
module mt_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] period,
  output logic [W-1:0] count,
  output logic         match_evt,
  output logic         match_q
);
  assign match_evt = tick && !load && (count == period);

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      match_q <= 1'b0;
    end else begin
      match_q <= match_evt;
      if (load)           count <= load_val;
      else if (match_evt) count <= '0;
      else if (tick)      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/mt_postscale.sv
module mt_postscale #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         evt,
  input  logic         clr,
  input  logic [W-1:0] code,
  output logic         term
);
  logic [W-1:0] post_q;

  assign term = evt && !clr && (post_q == code);

  always_ff @(posedge clk) begin
    if (rst || clr) post_q <= '0;
    else if (term)  post_q <= '0;
    else if (evt)   post_q <= post_q + 1'b1;
  end
endmodule

// File: rtl/match_timer.sv
module match_timer
  import mt_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int POST_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count_o,
  output logic             match_o,
  output logic             irq_flag_o,
  output logic             irq_o
);
  logic              ctrl_on;
  logic [1:0]        pre_code;
  logic [POST_W-1:0] post_code;
  logic [CNT_W-1:0]  period_q;
  logic              irq_en;
  logic              flag_q;

  logic wr_cnt, wr_per, wr_ctl, wr_irq, restart;
  logic tick, match_evt, post_term;

  assign wr_cnt  = wr_en && (wr_sel == SEL_CNT);
  assign wr_per  = wr_en && (wr_sel == SEL_PER);
  assign wr_ctl  = wr_en && (wr_sel == SEL_CTL);
  assign wr_irq  = wr_en && (wr_sel == SEL_IRQ);
  assign restart = wr_cnt || wr_ctl;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_on   <= 1'b0;
      pre_code  <= '0;
      post_code <= '0;
      period_q  <= '1;
      irq_en    <= 1'b0;
      flag_q    <= 1'b0;
    end else begin
      if (wr_ctl) begin
        ctrl_on   <= wr_data[CTL_ON];
        pre_code  <= wr_data[CTL_PRE_LO +: 2];
        post_code <= wr_data[CTL_POST_LO +: POST_W];
      end
      if (wr_per) period_q <= wr_data;
      if (wr_irq) irq_en <= wr_data[0];
      if (post_term)                flag_q <= 1'b1;
      else if (wr_irq && wr_data[1]) flag_q <= 1'b0;
    end
  end

  mt_prescale u_pre (
    .clk  (clk),
    .rst  (rst),
    .run  (ctrl_on),
    .clr  (restart),
    .code (pre_code),
    .tick (tick)
  );

  mt_count #(.W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .load      (wr_cnt),
    .load_val  (wr_data),
    .period    (period_q),
    .count     (count_o),
    .match_evt (match_evt),
    .match_q   (match_o)
  );

  mt_postscale #(.W(POST_W)) u_post (
    .clk  (clk),
    .rst  (rst),
    .evt  (match_evt),
    .clr  (restart),
    .code (post_code),
    .term (post_term)
  );

  assign irq_flag_o = flag_q;
  assign irq_o      = flag_q && irq_en;
endmodule

// File: rtl/match_timer_chk.sv
module match_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic [CNT_W-1:0] wr_data,
  input logic [CNT_W-1:0] count_o,
  input logic             match_o,
  input logic             irq_flag_o,
  input logic             ctrl_on
);
  // R4
  match_zero_chk: assert property (@(posedge clk) disable iff (rst)
    match_o |-> (count_o == '0));

  // R5
  flag_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_flag_o) |-> match_o);

  // R6
  flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_flag_o) |-> $past(wr_en && wr_sel == 2'd3 && wr_data[1]));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_on && !(wr_en && wr_sel == 2'd0)) |=> $stable(count_o));

  // R8
  load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd0) |=> (count_o == $past(wr_data)));
endmodule

bind match_timer match_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .wr_sel     (wr_sel),
  .wr_data    (wr_data),
  .count_o    (count_o),
  .match_o    (match_o),
  .irq_flag_o (irq_flag_o),
  .ctrl_on    (ctrl_on)
);

// File: tb/match_timer_test.sv
module match_timer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] count_o;
  logic       match_o, irq_flag_o, irq_o;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int exp_q[$];
  bit done = 1'b0;

  match_timer uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .count_o(count_o), .match_o(match_o), .irq_flag_o(irq_flag_o), .irq_o(irq_o)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: every match pulse must be the next expected one
  always @(negedge clk) begin
    if (!rst && match_o) begin
      if (exp_q.size() == 0) check("R4 unexpected match", cyc, -1);
      else check("R4 match cycle", cyc, exp_q.pop_front());
      check("R4 count zero at match", int'(count_o), 0);
    end
  end

  task automatic wr(input logic [1:0] s, input logic [7:0] d, output int e);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    e = cyc;
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic run_case(input logic [1:0] pre, input int p, input logic [3:0] post,
                          input logic en, input int nm);
    int e, d, per, tf;
    d   = (pre == 2'b00) ? 1 : ((pre == 2'b01) ? 4 : 16);
    per = (p + 1) * d;
    wr(2'd1, 8'(p), e);                        // R10
    wr(2'd0, 8'd0, e);
    wr(2'd3, {6'd0, 1'b1, en}, e);
    wr(2'd2, {1'b0, post, pre, 1'b1}, e);      // R9 restart
    for (int k = 1; k <= nm; k++) exp_q.push_back(e + k * per);
    tf = e + (int'(post) + 1) * per;
    if (p >= 1) begin
      wait_to(e + d);
      check("R2 R3 first tick", int'(count_o), 1);
      wait_to(e + d - 1 + (d > 1 ? 0 : 1));
    end
    wait_to(tf - 1);
    check("R5 flag before terminal", int'(irq_flag_o), 0);
    wait_to(tf);
    check("R5 flag at terminal", int'(irq_flag_o), 1);
    check("R7 irq follows enable", int'(irq_o), int'(en));
    wait_to(e + nm * per);
    wr(2'd2, 8'd0, e);
    check("R4 all matches seen", exp_q.size(), 0);
  endtask

  initial begin
    int e, ew, c0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 count", int'(count_o), 0);
    check("R1 match", int'(match_o), 0);
    check("R1 flag", int'(irq_flag_o), 0);
    check("R1 irq", int'(irq_o), 0);

    // R1 reset period all ones: full 256-tick wrap at divide-by-1
    wr(2'd3, 8'h01, e);
    wr(2'd2, 8'h01, e);
    exp_q.push_back(e + 256);
    wait_to(e + 256);
    check("R1 default period flag", int'(irq_flag_o), 1);
    wr(2'd2, 8'h00, e);

    // R6 clear
    wr(2'd3, 8'h03, e);
    check("R6 flag cleared", int'(irq_flag_o), 0);

    run_case(2'b00, 3, 4'd0, 1'b1, 3);
    run_case(2'b01, 2, 4'd2, 1'b0, 4);
    run_case(2'b10, 1, 4'd1, 1'b1, 3);
    run_case(2'b11, 0, 4'd15, 1'b1, 16);

    // R2 hold while stopped
    c0 = int'(count_o);
    repeat (10) @(negedge clk);
    check("R2 hold when off", int'(count_o), c0);

    // R8 counter write mid-run restarts prescaler and postscaler
    wr(2'd1, 8'd9, e);
    wr(2'd0, 8'd0, e);
    wr(2'd3, 8'h03, e);
    wr(2'd2, {1'b0, 4'd1, 2'b01, 1'b1}, e);
    exp_q.push_back(e + 40);
    wait_to(e + 50);
    wr(2'd0, 8'd5, ew);
    check("R8 loaded value", int'(count_o), 5);
    exp_q.push_back(ew + 20);
    exp_q.push_back(ew + 60);
    wait_to(ew + 20);
    check("R8 postscaler restarted", int'(irq_flag_o), 0);
    wait_to(ew + 60);
    check("R8 flag after two matches", int'(irq_flag_o), 1);
    wr(2'd2, 8'd0, e);
    check("R4 all matches seen", exp_q.size(), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule